// File: doc/BRIEF.md
# Shared Mailbox Interrupt Hub

This block holds a small bank of 32-bit mailbox words that two agents use to pass short messages. The top bit of each word is the occupancy flag: a producer posts a message by writing the 31-bit payload with that bit set, and a consumer retires it by writing the whole word to zero. Because the flag travels inside the data word, one register write both delivers the payload and marks the slot occupied.

Every mailbox produces two level conditions, EMPTY and FULL. One status register packs these conditions for all mailboxes. Several shared interrupt lines each have their own 16-bit mask in the same bit layout. A line is high for as long as any condition that its mask selects is present and that mailbox's own per-condition enable is set. A vector register reports the lowest active line. A read-only sizing register reports how many of each resource the instance was built with.

Access is over a simple single-cycle request bus. Writes take effect at the clock edge that samples the request. Read data returns one cycle after the request, together with a valid strobe.

Top module: `mbox_irq_hub`

## Requirements
- R1: After reset every mailbox word reads zero, every mask and per-mailbox enable reads zero, the status register reads 0x000000FF (all eight mailboxes empty), every interrupt line is low and the vector register reads 0xFFFFFFFF.
- R2: A write to the data word of mailbox i (byte address 0x10000 + i*0x8000) stores all 32 bits. Bit 31 is the FULL flag and bits 30:0 are the payload. A later read returns the stored word unchanged.
- R3: Writing zero to a mailbox data word clears the payload and the FULL flag together, so the mailbox reports EMPTY again from the cycle after the write.
- R4: The status register at 0x304 holds, for mailbox i, its FULL flag in bit 8+i and the inverse of that flag (EMPTY) in bit i. Bits 31:16 read zero.
- R5: The mask for interrupt line x lives at 0x100 + 4*x. It holds 16 bits in the status layout, reads back what was written in bits 15:0, and reads zero in bits 31:16.
- R6: Interrupt line x is high exactly when, for some mailbox i, either (EMPTY_i, its EMPTY enable and mask bit i) are all set, or (FULL_i, its FULL enable and mask bit 8+i) are all set. The line stays high for every cycle in which that holds, and it changes in the cycle after the write that alters the condition.
- R7: Each mailbox window has a FULL enable at +0x4 and an EMPTY enable at +0x8. Each stores write-data bit 0 and reads it back in bit 0, with all other bits zero.
- R8: The vector register at 0x300 reads the index of the lowest-numbered interrupt line that is high, or 0xFFFFFFFF when no line is high.
- R9: The sizing register at 0x380 reads the mailbox count in bits 3:0, the shared semaphore count in bits 7:4, the arbitrated semaphore count in bits 11:8, the doorbell count in bits 15:12 and the interrupt line count in bits 19:16. All higher bits are zero. With the defaults it reads 0x00046248.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses, to the status register, to the vector register or to the sizing register change no readable state and no interrupt line.
- R11: A read request is answered in the next cycle with the read-valid strobe high. The strobe is low in every cycle that does not follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| bus_req | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| bus_rdata | output | 32 | Read data |
| irq | output | NUM_LINES | Level interrupt lines, one per mask register |

## Verification
The hardest case to reach is a line that is held only by EMPTY conditions, and then two lines that are active at once while the vector register has to name the lower one. Mailboxes start empty, so any EMPTY enable together with a mask bit raises a line at once. The random stimulus therefore mixes many zero writes with posted words, and it sets enables and masks in random order. This makes lines rise and fall on all three causes (status, enable, mask). Directed sequences then hold a line high across idle cycles, raise two lines together to check the vector, and push writes at read-only and unmapped addresses while the lines are watched.

// File: rtl/mbox_hub_pkg.sv
package mbox_hub_pkg;

    localparam int unsigned WORD_W      = 32;
    localparam int unsigned MAX_MBOX    = 8;
    localparam int unsigned STAT_W      = 2 * MAX_MBOX;

    // register offsets; the status layout is shared by the masks
    localparam int unsigned OFS_MASK0   = 32'h100;
    localparam int unsigned OFS_VECTOR  = 32'h300;
    localparam int unsigned OFS_STATUS  = 32'h304;
    localparam int unsigned OFS_SIZING  = 32'h380;

    // mailbox windows
    localparam int unsigned SLOT_BASE   = 32'h1_0000;
    localparam int unsigned SLOT_STRIDE = 32'h8000;
    localparam int unsigned SLOT_WORD   = 32'h0;
    localparam int unsigned SLOT_FIE    = 32'h4;
    localparam int unsigned SLOT_EIE    = 32'h8;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              full_ie;
        logic              empty_ie;
    } slot_state_t;

    typedef struct packed {
        logic              rvalid;
        logic [WORD_W-1:0] rdata;
    } rd_state_t;

    function automatic int unsigned slot_addr(input int unsigned idx, input int unsigned ofs);
        return SLOT_BASE + idx * SLOT_STRIDE + ofs;
    endfunction

endpackage

// File: rtl/mbox_hub_slot.sv
module mbox_hub_slot
    import mbox_hub_pkg::*;
#(
    parameter bit HAS_IE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_word,
    input  logic              wr_fie,
    input  logic              wr_eie,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] word_o,
    output logic              full_ie_o,
    output logic              empty_ie_o
);

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the occupancy flag rides in bit 31, so a single store updates both
        if (wr_word) begin
            st_d.word = wdata;
        end
        if (HAS_IE) begin
            if (wr_fie) begin
                st_d.full_ie = wdata[0];
            end
            if (wr_eie) begin
                st_d.empty_ie = wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o     = st_q.word;
    assign full_ie_o  = st_q.full_ie;
    assign empty_ie_o = st_q.empty_ie;

endmodule

// File: rtl/mbox_hub_route.sv
module mbox_hub_route
    import mbox_hub_pkg::*;
#(
    parameter int unsigned NUM_LINES = 4,
    localparam int unsigned LSEL_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mask_we,
    input  logic [LSEL_W-1:0]                 mask_sel,
    input  logic [STAT_W-1:0]                 mask_wdata,
    input  logic [STAT_W-1:0]                 src,
    output logic [NUM_LINES-1:0][STAT_W-1:0]  mask_o,
    output logic [NUM_LINES-1:0]              irq_o,
    output logic [WORD_W-1:0]                 first_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0][STAT_W-1:0] mask;
    } route_state_t;

    route_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) begin
            st_d.mask[mask_sel] = mask_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        assign irq_o[l] = |(src & st_q.mask[l]);
    end

    // lowest active line wins; all ones when idle
    always_comb begin
        first_o = '1;
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            if (irq_o[k]) begin
                first_o = WORD_W'(k);
            end
        end
    end

    assign mask_o = st_q.mask;

endmodule

// File: rtl/mbox_irq_hub.sv
module mbox_irq_hub
    import mbox_hub_pkg::*;
#(
    parameter int unsigned NUM_MBOX    = 8,
    parameter int unsigned NUM_LINES   = 4,
    parameter int unsigned NUM_SHSEM   = 4,
    parameter int unsigned NUM_ARSEM   = 2,
    parameter int unsigned NUM_DBELL   = 6,
    parameter int unsigned ADDR_W      = 20,
    parameter bit          HAS_MBOX_IE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic                 bus_rvalid,
    output logic [WORD_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq
);

    localparam int unsigned LSEL_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [WORD_W-1:0] SIZING = {12'h0, 4'(NUM_LINES), 4'(NUM_DBELL),
                                            4'(NUM_ARSEM), 4'(NUM_SHSEM), 4'(NUM_MBOX)};

    logic [NUM_MBOX-1:0]                wr_word, wr_fie, wr_eie;
    logic [NUM_MBOX-1:0][WORD_W-1:0]    word;
    logic [NUM_MBOX-1:0]                fie, eie, full_vec;
    logic [STAT_W-1:0]                  raw_stat, eff_stat;
    logic                               mask_we;
    logic [LSEL_W-1:0]                  mask_sel;
    logic [NUM_LINES-1:0][STAT_W-1:0]   mask_val;
    logic [WORD_W-1:0]                  first_line;
    rd_state_t                          rd_d, rd_q;

    // write decode
    always_comb begin
        wr_word  = '0;
        wr_fie   = '0;
        wr_eie   = '0;
        mask_we  = 1'b0;
        mask_sel = '0;
        if (bus_req && bus_we) begin
            for (int unsigned i = 0; i < NUM_MBOX; i++) begin
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_WORD))) wr_word[i] = 1'b1;
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_FIE)))  wr_fie[i]  = 1'b1;
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_EIE)))  wr_eie[i]  = 1'b1;
            end
            for (int unsigned l = 0; l < NUM_LINES; l++) begin
                if (bus_addr == ADDR_W'(OFS_MASK0 + 4 * l)) begin
                    mask_we  = 1'b1;
                    mask_sel = LSEL_W'(l);
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_slot
        mbox_hub_slot #(
            .HAS_IE(HAS_MBOX_IE)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_word   (wr_word[g]),
            .wr_fie    (wr_fie[g]),
            .wr_eie    (wr_eie[g]),
            .wdata     (bus_wdata),
            .word_o    (word[g]),
            .full_ie_o (fie[g]),
            .empty_ie_o(eie[g])
        );
        assign full_vec[g] = word[g][WORD_W-1];
    end

    // status packing and per-mailbox gating
    for (genvar g = 0; g < MAX_MBOX; g++) begin : g_stat
        if (g < NUM_MBOX) begin : g_live
            assign raw_stat[g]            = ~full_vec[g];
            assign raw_stat[MAX_MBOX + g] = full_vec[g];
            if (HAS_MBOX_IE) begin : g_gate
                assign eff_stat[g]            = raw_stat[g] & eie[g];
                assign eff_stat[MAX_MBOX + g] = raw_stat[MAX_MBOX + g] & fie[g];
            end else begin : g_nogate
                assign eff_stat[g]            = raw_stat[g];
                assign eff_stat[MAX_MBOX + g] = raw_stat[MAX_MBOX + g];
            end
        end else begin : g_absent
            assign raw_stat[g]            = 1'b0;
            assign raw_stat[MAX_MBOX + g] = 1'b0;
            assign eff_stat[g]            = 1'b0;
            assign eff_stat[MAX_MBOX + g] = 1'b0;
        end
    end

    mbox_hub_route #(
        .NUM_LINES(NUM_LINES)
    ) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_sel  (mask_sel),
        .mask_wdata(bus_wdata[STAT_W-1:0]),
        .src       (eff_stat),
        .mask_o    (mask_val),
        .irq_o     (irq),
        .first_o   (first_line)
    );

    // read path: one registered stage
    always_comb begin
        rd_d.rvalid = bus_req && !bus_we;
        rd_d.rdata  = '0;
        if (bus_req && !bus_we) begin
            if (bus_addr == ADDR_W'(OFS_VECTOR)) rd_d.rdata = first_line;
            if (bus_addr == ADDR_W'(OFS_STATUS)) rd_d.rdata = WORD_W'(raw_stat);
            if (bus_addr == ADDR_W'(OFS_SIZING)) rd_d.rdata = SIZING;
            for (int unsigned l = 0; l < NUM_LINES; l++) begin
                if (bus_addr == ADDR_W'(OFS_MASK0 + 4 * l)) rd_d.rdata = WORD_W'(mask_val[l]);
            end
            for (int unsigned i = 0; i < NUM_MBOX; i++) begin
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_WORD))) rd_d.rdata = word[i];
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_FIE)))  rd_d.rdata = WORD_W'(fie[i]);
                if (bus_addr == ADDR_W'(slot_addr(i, SLOT_EIE)))  rd_d.rdata = WORD_W'(eie[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rvalid = rd_q.rvalid;
    assign bus_rdata  = rd_q.rdata;

endmodule

// File: rtl/mbox_irq_hub_chk.sv
module mbox_irq_hub_chk
    import mbox_hub_pkg::*;
#(
    parameter int unsigned NUM_MBOX  = 8,
    parameter int unsigned NUM_LINES = 4,
    parameter int unsigned ADDR_W    = 20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic                 bus_rvalid,
    input logic [WORD_W-1:0]    bus_rdata,
    input logic [NUM_LINES-1:0] irq,
    input logic [NUM_MBOX-1:0]  full_vec,
    input logic [STAT_W-1:0]    eff_stat
);

    localparam logic [ADDR_W-1:0] SLOT0 = ADDR_W'(SLOT_BASE);

    assert_read_answered_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    assert_no_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_we) |=> !bus_rvalid);

    assert_idle_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr == ADDR_W'(OFS_VECTOR) && irq == '0)
        |=> (bus_rdata == '1));

    assert_post_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == SLOT0 && bus_wdata[WORD_W-1]) |=> full_vec[0]);

    assert_zero_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == SLOT0 && bus_wdata == '0) |=> !full_vec[0]);

    assert_line_needs_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> (eff_stat != '0));

endmodule

bind mbox_irq_hub mbox_irq_hub_chk #(
    .NUM_MBOX (NUM_MBOX),
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rvalid(bus_rvalid),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .full_vec  (full_vec),
    .eff_stat  (eff_stat)
);

// File: tb/mbox_irq_hub_tb_top.sv
module mbox_irq_hub_tb_top;

    localparam int NMB = 8;
    localparam int NLN = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [19:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid;
    logic [31:0] bus_rdata;
    logic [NLN-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic [31:0] m_word [NMB];
    logic        m_fie  [NMB];
    logic        m_eie  [NMB];
    logic [15:0] m_mask [NLN];

    always #2.5 clk = ~clk;

    mbox_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [19:0] a_word(int i); return 20'h10000 + 20'(i) * 20'h8000; endfunction
    function automatic logic [19:0] a_mask(int l); return 20'h100 + 20'(4 * l); endfunction

    function automatic logic [15:0] m_status();
        logic [15:0] s;
        for (int i = 0; i < NMB; i++) begin
            s[i]     = ~m_word[i][31];
            s[8 + i] = m_word[i][31];
        end
        return s;
    endfunction

    function automatic logic [NLN-1:0] m_irq();
        logic [15:0] src;
        logic [NLN-1:0] r;
        src = m_status();
        for (int i = 0; i < NMB; i++) begin
            src[i]     = src[i] & m_eie[i];
            src[8 + i] = src[8 + i] & m_fie[i];
        end
        for (int l = 0; l < NLN; l++) r[l] = |(src & m_mask[l]);
        return r;
    endfunction

    function automatic logic [31:0] m_vector();
        logic [NLN-1:0] r;
        r = m_irq();
        for (int l = 0; l < NLN; l++) if (r[l]) return 32'(l);
        return 32'hFFFF_FFFF;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [19:0] a, logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [19:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check("R11 rvalid", 32'(bus_rvalid), 32'd1);
        d = bus_rdata;
    endtask

    // model update for a write
    task automatic mwr(logic [19:0] a, logic [31:0] d);
        for (int i = 0; i < NMB; i++) begin
            if (a == a_word(i)) m_word[i] = d;
            if (a == a_word(i) + 20'h4) m_fie[i] = d[0];
            if (a == a_word(i) + 20'h8) m_eie[i] = d[0];
        end
        for (int l = 0; l < NLN; l++) if (a == a_mask(l)) m_mask[l] = d[15:0];
        wr(a, d);
    endtask

    function automatic logic [31:0] m_read(logic [19:0] a);
        if (a == 20'h300) return m_vector();
        if (a == 20'h304) return {16'h0, m_status()};
        if (a == 20'h380) return 32'h0004_6248;
        for (int l = 0; l < NLN; l++) if (a == a_mask(l)) return {16'h0, m_mask[l]};
        for (int i = 0; i < NMB; i++) begin
            if (a == a_word(i)) return m_word[i];
            if (a == a_word(i) + 20'h4) return 32'(m_fie[i]);
            if (a == a_word(i) + 20'h8) return 32'(m_eie[i]);
        end
        return 32'h0;
    endfunction

    task automatic rchk(string req, logic [19:0] a);
        logic [31:0] v;
        logic [31:0] e;
        e = m_read(a);
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic irq_chk(string req);
        check(req, 32'(irq), 32'(m_irq()));
    endtask

    function automatic logic [19:0] pick_addr(int k);
        int i;
        i = int'($urandom % NMB);
        case (k)
            0: return a_word(i);
            1: return a_word(i) + 20'h4;
            2: return a_word(i) + 20'h8;
            3: return a_mask(int'($urandom % NLN));
            4: return 20'h304;
            5: return 20'h300;
            default: return 20'h380;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < NMB; i++) begin m_word[i] = '0; m_fie[i] = 0; m_eie[i] = 0; end
        for (int l = 0; l < NLN; l++) m_mask[l] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 irq after reset", 32'(irq), 32'h0);
        rd(20'h304, v); check("R1 status after reset", v, 32'h0000_00FF);
        rd(20'h300, v); check("R1 vector after reset", v, 32'hFFFF_FFFF);
        for (int i = 0; i < NMB; i++) rchk("R1 mailbox word after reset", a_word(i));
        for (int l = 0; l < NLN; l++) rchk("R1 mask after reset", a_mask(l));
        rchk("R1 empty enable after reset", a_word(5) + 20'h8);

        // R9 sizing
        rd(20'h380, v); check("R9 sizing", v, 32'h0004_6248);

        // R2 / R4 / R3 directed
        mwr(a_word(2), 32'h8000_1234);
        rchk("R2 word readback", a_word(2));
        rd(20'h304, v); check("R4 status with mailbox 2 full", v, 32'h0000_04FB);
        mwr(a_word(2), 32'h0);
        rd(20'h304, v); check("R3 status after zero write", v, 32'h0000_00FF);
        rchk("R3 word cleared", a_word(2));

        // R7 enables
        mwr(a_word(3) + 20'h8, 32'hFFFF_FFFF);
        rd(a_word(3) + 20'h8, v); check("R7 empty enable readback", v, 32'h1);
        // R5 mask upper bits dropped
        mwr(a_mask(1), 32'hABCD_0008);
        rd(a_mask(1), v); check("R5 mask readback", v, 32'h0000_0008);
        // R6 empty level held
        check("R6 line1 on empty", 32'(irq), 32'h2);
        repeat (5) @(negedge clk);
        check("R6 line1 held", 32'(irq), 32'h2);
        rd(20'h300, v); check("R8 vector line1", v, 32'h1);
        // second line on the full condition of mailbox 0
        mwr(a_word(0) + 20'h4, 32'h1);
        mwr(a_mask(2), 32'h0000_0100);
        mwr(a_mask(0), 32'h0000_0100);
        check("R6 no full yet", 32'(irq), 32'h2);
        mwr(a_word(0), 32'h8000_0001);
        check("R6 full raises lines 0 and 2", 32'(irq), 32'h7 & 32'(m_irq()));
        rd(20'h300, v); check("R8 lowest line wins", v, 32'h0);
        mwr(a_word(3), 32'hC000_0000);
        check("R6 line1 drops when mailbox 3 fills", 32'(irq), 32'h5);

        // R10 writes to read-only and unmapped
        wr(20'h304, 32'h0); wr(20'h380, 32'h0); wr(20'h300, 32'h0); wr(20'h0_0200, 32'hFFFF_FFFF);
        irq_chk("R10 lines unchanged after ignored writes");
        rchk("R10 status unchanged", 20'h304);
        rchk("R10 sizing unchanged", 20'h380);
        rd(20'h0_0200, v); check("R10 unmapped reads zero", v, 32'h0);
        rd(a_word(0) + 20'hC, v); check("R10 hole in window reads zero", v, 32'h0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [31:0] d;
            logic [19:0] a;
            op = int'($urandom % 9);
            d  = $urandom;
            if (op <= 2) begin
                if ($urandom % 2 == 0) d = 32'h0;
                mwr(pick_addr(0), d);
                irq_chk("R6 random data write");
            end else if (op == 3) begin
                mwr(pick_addr(1), d);
                irq_chk("R6 random full enable");
            end else if (op == 4) begin
                mwr(pick_addr(2), d);
                irq_chk("R6 random empty enable");
            end else if (op == 5) begin
                mwr(pick_addr(3), d);
                irq_chk("R6 random mask");
            end else if (op == 6 || op == 7) begin
                a = pick_addr(int'($urandom % 7));
                rchk("R2 R4 R5 R7 R8 random readback", a);
            end else begin
                wr(20'h0_0400 + 20'($urandom % 256) * 20'h4, d);
                irq_chk("R10 random unmapped write");
            end
        end

        // R11 strobe low after write
        wr(a_word(1), 32'h0);
        check("R11 no valid after write", 32'(bus_rvalid), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule